// File: doc/BRIEF.md
# Parallel Panel Bus Master

This block is the master side of a 16-bit, 80-series style parallel CPU bus to an LCD or OLED panel controller. It drives an active-low chip select, a register-select line, active-low read and write strobes, and an active-low panel reset. It also owns the tri-state control of the shared bidirectional 16-bit data bus. A client issues one transfer at a time through a valid/kind/data command port. The block then runs a complete bus cycle whose phase lengths come from nanosecond parameters, converted to clock cycles and rounded up. Each cycle ends with a single-cycle done pulse, and read data is returned on that pulse.

After system reset the block first holds the panel in reset for a parameterised time, then waits a further recovery time before it accepts commands. The state machine has five states. ST_PANEL_RST holds the panel in reset and moves to ST_IDLE once the reset and recovery time has elapsed. ST_IDLE moves to ST_SETUP when a command is accepted. ST_SETUP asserts select and sets RS; for writes it drives the bus. It moves to ST_STROBE when its setup time expires. ST_STROBE holds the read or write strobe low. When the low time expires it moves to ST_RECOVER, capturing read data and raising done. ST_RECOVER keeps all lines inactive for the strobe-high time and then returns to ST_IDLE. Read timing is about three times slower than write timing.

Top module: `disp_bus_master`

## Requirements
- R1: The two-bit command kind selects RS and direction. Kind 0 is an index write (RS=0). Kind 1 is a status read (RS=0). Kind 2 is a register or pixel-data write (RS=1). Kind 3 is a pixel-memory read (RS=1). RS stays stable while chip select is low.
- R2: Chip select is low only in ST_SETUP and ST_STROBE, that is for setup plus strobe-low cycles. Read and write strobes are never low together, and neither is low while chip select is high.
- R3: A write holds the write strobe low for ceil(WR_LO_NS/CLK_NS) cycles, which is 5 by default. The recovery phase gives at least 50 ns high time and at least 100 ns total cycle time. Write data is on the bus from the setup cycle until the strobe rises.
- R4: A read holds the read strobe low for ceil(RD_LO_NS/CLK_NS) cycles, which is 15 by default. It is followed by at least 150 ns high time, with a total cycle time of at least 300 ns.
- R5: The block drives the data bus only in the setup and strobe phases of write kinds. It never drives the bus while the read strobe is low.
- R6: Read data is sampled on the last clock edge of the read-strobe-low phase and appears on rdata with done. Done is high for exactly one cycle per accepted command.
- R7: Busy is high from the cycle after acceptance for setup+low+high cycles: 11 for writes and 31 for reads by default. A command presented while busy is ignored.
- R8: After reset the panel reset output stays low for ceil(RST_LO_NS/CLK_NS) cycles, which is 30 by default. Busy stays high for the reset and recovery time plus one cycle (51 by default), and commands offered in that time are ignored.
- R9: While system reset is asserted, chip select and both strobes are high, panel reset is low and busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| cmd_valid | input | 1 | Command request, accepted when not busy |
| cmd_kind | input | 2 | Transfer kind (see R1) |
| cmd_wdata | input | 16 | Write data for write kinds |
| busy | output | 1 | Block cannot accept a command |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data captured by the last read |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select: 0 index/status, 1 data |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_data | inout | 16 | Bidirectional panel data bus |

## Verification
The assertions check the following on every cycle: the mutual exclusion of the strobes, strobes appearing only under chip select, RS stability during a selected cycle, bus release whenever the read strobe is low, the single-cycle done pulse, and busy during panel reset. The bench checks what only whole scenarios can show. These are the exact strobe-low and busy lengths derived from the nanosecond figures, the data seen by a panel model at the setup cycle and at the strobe edge, and the read data returned. It also checks that commands offered while busy or during panel reset produce no strobe at all. It sweeps every kind against several data patterns.

// File: rtl/disp_bus_pkg.sv
package disp_bus_pkg;

    typedef enum logic [1:0] {
        K_IDX_WR  = 2'd0,
        K_STAT_RD = 2'd1,
        K_DAT_WR  = 2'd2,
        K_PIX_RD  = 2'd3
    } xfer_kind_t;

    typedef enum logic [2:0] {
        ST_PANEL_RST,
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } bus_state_t;

    function automatic int cyc_ceil(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/disp_phase_timer.sv
module disp_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/disp_panel_reset.sv
module disp_panel_reset #(
    parameter int LO_CYC   = 30,
    parameter int WAIT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic panel_rst_n,
    output logic ready
);
    localparam int TOT = LO_CYC + WAIT_CYC;
    localparam int W   = $clog2(TOT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != W'(TOT))
            cnt <= cnt + 1'b1;
    end

    assign panel_rst_n = (cnt >= W'(LO_CYC));
    assign ready       = (cnt == W'(TOT));

    // R8: panel reset must have released before the block is ready
    p_ready_after_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> panel_rst_n);
endmodule

// File: rtl/disp_bus_master.sv
module disp_bus_master
    import disp_bus_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CLK_NS      = 10,
    parameter int WR_LO_NS    = 50,
    parameter int WR_HI_NS    = 50,
    parameter int WR_CYC_NS   = 100,
    parameter int WR_SU_NS    = 25,
    parameter int RD_LO_NS    = 150,
    parameter int RD_HI_NS    = 150,
    parameter int RD_CYC_NS   = 300,
    parameter int RST_LO_NS   = 300,
    parameter int RST_WAIT_NS = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_kind,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          lcd_cs_n,
    output logic          lcd_rs,
    output logic          lcd_rd_n,
    output logic          lcd_wr_n,
    output logic          lcd_rst_n,
    inout  wire  [DW-1:0] lcd_data
);
    localparam int WR_LO  = imax(1, cyc_ceil(WR_LO_NS, CLK_NS));
    localparam int WR_HI  = imax(imax(1, cyc_ceil(WR_HI_NS, CLK_NS)),
                                 cyc_ceil(WR_CYC_NS, CLK_NS) - WR_LO);
    localparam int WR_SU  = imax(1, cyc_ceil(WR_SU_NS, CLK_NS) - WR_LO);
    localparam int RD_LO  = imax(1, cyc_ceil(RD_LO_NS, CLK_NS));
    localparam int RD_HI  = imax(imax(1, cyc_ceil(RD_HI_NS, CLK_NS)),
                                 cyc_ceil(RD_CYC_NS, CLK_NS) - RD_LO);
    localparam int RD_SU  = 1;
    localparam int RST_LO = imax(1, cyc_ceil(RST_LO_NS, CLK_NS));
    localparam int RST_WT = imax(1, cyc_ceil(RST_WAIT_NS, CLK_NS));
    localparam int MAXC   = imax(imax(imax(WR_LO, WR_HI), imax(RD_LO, RD_HI)),
                                 imax(WR_SU, RD_SU));
    localparam int CW     = $clog2(MAXC + 1);

    bus_state_t    st, nxt;
    logic          tmr_load, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          rst_ready, panel_rst_n;
    xfer_kind_t    kind_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          done_q;
    logic          is_rd;
    logic          bus_oe;

    disp_phase_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    disp_panel_reset #(.LO_CYC(RST_LO), .WAIT_CYC(RST_WT)) u_prst (
        .clk         (clk),
        .rst_n       (rst_n),
        .panel_rst_n (panel_rst_n),
        .ready       (rst_ready)
    );

    assign is_rd = kind_q[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_PANEL_RST;
        else
            st <= nxt;
    end

    // transitions and phase timer loads
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_PANEL_RST: begin
                if (rst_ready) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = cmd_kind[0] ? CW'(RD_SU - 1) : CW'(WR_SU - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = is_rd ? CW'(RD_LO - 1) : CW'(WR_LO - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    nxt      = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = is_rd ? CW'(RD_HI - 1) : CW'(WR_HI - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // command latch, read capture, done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_IDX_WR;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (st == ST_IDLE && cmd_valid) begin
                kind_q  <= xfer_kind_t'(cmd_kind);
                wdata_q <= cmd_wdata;
            end
            done_q <= (st == ST_STROBE) && tmr_zero;
            if (st == ST_STROBE && tmr_zero && is_rd)
                rdata_q <= lcd_data;
        end
    end

    // outputs decoded from state
    always_comb begin
        lcd_cs_n = 1'b1;
        lcd_rd_n = 1'b1;
        lcd_wr_n = 1'b1;
        bus_oe   = 1'b0;
        unique case (st)
            ST_SETUP: begin
                lcd_cs_n = 1'b0;
                bus_oe   = !is_rd;
            end
            ST_STROBE: begin
                lcd_cs_n = 1'b0;
                lcd_rd_n = !is_rd;
                lcd_wr_n = is_rd;
                bus_oe   = !is_rd;
            end
            default: ;
        endcase
    end

    assign lcd_rs    = kind_q[1];
    assign lcd_rst_n = panel_rst_n;
    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign lcd_data  = bus_oe ? wdata_q : {DW{1'bz}};

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lcd_rd_n && !lcd_wr_n));
    p_strobe_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_rd_n || !lcd_wr_n) |-> !lcd_cs_n);
    p_rs_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_rs));
    p_oe_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n |-> !bus_oe);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rst_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> busy);
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lcd_cs_n && lcd_rd_n && lcd_wr_n));
endmodule

// File: tb/disp_bus_master_bench.sv
module disp_bus_master_bench;
    localparam int CLK = 10;
    localparam int WLO = (50 + CLK - 1) / CLK;
    localparam int WHI = 5;
    localparam int WSU = 1;
    localparam int RLO = (150 + CLK - 1) / CLK;
    localparam int RHI = 15;
    localparam int RSU = 1;
    localparam int PRLO = 30;
    localparam int PRWT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [15:0] cmd_wdata = 16'h0;
    logic        busy, done, lcd_cs_n, lcd_rs, lcd_rd_n, lcd_wr_n, lcd_rst_n;
    logic [15:0] rdata;
    wire  [15:0] lcd_data;
    logic [15:0] pan_val = 16'h0;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    int busy_c, done_c, wr_lo_c, rd_lo_c, cs_lo_c, wr_fall_c, rd_fall_c;
    logic [15:0] bus_at_wr, bus_at_su;
    logic rs_at_stb;
    logic prev_wr, prev_rd, prev_busy;

    always #5 clk = ~clk;

    assign lcd_data = (!lcd_rd_n) ? pan_val : 16'hzzzz;

    disp_bus_master u_disp_bus_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rdata(rdata),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_rd_n(lcd_rd_n),
        .lcd_wr_n(lcd_wr_n), .lcd_rst_n(lcd_rst_n), .lcd_data(lcd_data)
    );

    task automatic clr();
        busy_c = 0; done_c = 0; wr_lo_c = 0; rd_lo_c = 0; cs_lo_c = 0;
        wr_fall_c = 0; rd_fall_c = 0; bus_at_wr = 16'h0; bus_at_su = 16'h0;
        rs_at_stb = 1'b0; prev_wr = 1'b1; prev_rd = 1'b1; prev_busy = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_c++;
            if (busy && !prev_busy && !lcd_cs_n) bus_at_su = lcd_data;
            if (done) done_c++;
            if (!lcd_cs_n) cs_lo_c++;
            if (!lcd_wr_n) begin wr_lo_c++; bus_at_wr = lcd_data; rs_at_stb = lcd_rs; end
            if (!lcd_rd_n) begin rd_lo_c++; rs_at_stb = lcd_rs; end
            if (prev_wr && !lcd_wr_n) wr_fall_c++;
            if (prev_rd && !lcd_rd_n) rd_fall_c++;
            prev_wr = lcd_wr_n; prev_rd = lcd_rd_n; prev_busy = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic do_op(input logic [1:0] k, input logic [15:0] d);
        bit rd = k[0];
        int lo = rd ? RLO : WLO;
        int su = rd ? RSU : WSU;
        int hi = rd ? RHI : WHI;
        while (busy) @(negedge clk);
        pan_val = ~d ^ {14'h0, k};
        clr();
        cmd_kind = k; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        chk(busy_c == su + lo + hi, "R7", "busy length", busy_c, su + lo + hi);
        chk(done_c == 1, "R6", "done pulses", done_c, 1);
        chk(cs_lo_c == su + lo, "R2", "cs low length", cs_lo_c, su + lo);
        chk(rs_at_stb == k[1], "R1", "rs level", rs_at_stb, k[1]);
        if (rd) begin
            chk(rd_lo_c == lo && wr_lo_c == 0, "R4", "read strobe low", rd_lo_c, lo);
            chk(rdata == pan_val, "R6", "read data", rdata, pan_val);
        end else begin
            chk(wr_lo_c == lo && rd_lo_c == 0, "R3", "write strobe low", wr_lo_c, lo);
            chk(bus_at_wr == d, "R5", "bus at write edge", bus_at_wr, d);
            chk(bus_at_su == d, "R3", "bus at setup", bus_at_su, d);
        end
    endtask

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
        pats[3] = 16'h5A5A; pats[4] = 16'h0001; pats[5] = 16'h8000;
        clr();
        repeat (3) @(negedge clk);
        // R9: outputs while reset is held
        chk(lcd_cs_n && lcd_rd_n && lcd_wr_n, "R9", "strobes idle in reset",
            {lcd_cs_n, lcd_rd_n, lcd_wr_n}, 3'b111);
        chk(!lcd_rst_n && busy, "R9", "panel reset and busy", {lcd_rst_n, busy}, 2'b01);

        // R8: panel reset pulse, command ignored while it runs
        rst_n = 1'b1;
        clr();
        begin
            int rl = 0, bc = 0;
            for (int i = 0; i < PRLO + PRWT + 6; i++) begin
                if (!lcd_rst_n) rl++;
                if (busy) bc++;
                cmd_valid = (i == 5);
                cmd_kind  = 2'd2;
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            chk(rl == PRLO, "R8", "panel reset low length", rl, PRLO);
            chk(bc == PRLO + PRWT + 1, "R8", "busy during panel reset", bc, PRLO + PRWT + 1);
            chk(wr_fall_c == 0 && rd_fall_c == 0, "R8", "no strobe during reset",
                wr_fall_c + rd_fall_c, 0);
        end

        // R1 R3 R4 R5 R6 R7: sweep over kinds and patterns
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 4; k++)
                do_op(2'(k), pats[p] ^ 16'(k * 16'h1111));

        // R7: command during busy ignored
        clr();
        cmd_kind = 2'd2; cmd_wdata = 16'h1234; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        cmd_kind = 2'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rd_fall_c == 0 && wr_fall_c == 1, "R7", "busy command ignored",
            rd_fall_c * 16 + wr_fall_c, 1);
        chk(busy_c == WSU + WLO + WHI, "R7", "single busy window", busy_c, WSU + WLO + WHI);
        chk(done_c == 1, "R6", "one done for ignored pair", done_c, 1);

        summary();
    end
endmodule